// File: doc/BRIEF.md
# Fixed-Point Transposed Biquad Section

This block is one second-order IIR section in transposed direct form II, fed by a stream of 16-bit signed audio samples. Five 32-bit Q28 coefficients set the response: three feed-forward taps (`coef_b0`, `coef_b1`, `coef_b2`) and two feedback taps (`coef_a1`, `coef_a2`). The feedback taps are entered with their natural sign and are negated inside the block. Each channel keeps two 32-bit state words in Q12. The arithmetic follows a fixed integer sequence exactly, so results match a bit-exact software model.

With `stereo` low the stream is mono and uses channel slot 0. With `stereo` high the samples are interleaved: the first sample after reset or clear belongs to slot 0, the next to slot 1, and so on. Both slots share the coefficients but keep separate state. Coefficients and `stereo` may only change while no samples are in flight.

Both stream sides use valid/ready handshakes. A sample transfers on a rising edge where `in_valid` and `in_ready` are both high. A result transfers where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the result and its valid are held. `in_ready` is high when the output register is empty or is draining in the same cycle, and `clr_state` is low.

Top module: `biquad_df2t`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and all state words are zero.
- R2: Every accepted sample yields exactly one result, in input order. `out_valid` is high in the cycle right after acceptance.
- R3: With x the sample, let f(c) = (c·x) >> 16, computed arithmetically on the full 48-bit product. The Q14 intermediate is y = (S0 + f(b0)) << 2, in 32-bit wrap-around arithmetic.
- R4: Let g(a) = (y·(−a) + 2^29) >> 30, computed arithmetically on a 64-bit product, where −a is a 32-bit negation. The next S0 is S1 + g(a1) + f(b1).
- R5: The next S1 is g(a2) + f(b2).
- R6: The result is (y + 16383) >> 14 (arithmetic shift), saturated to the range −32768..32767.
- R7: With `stereo` = 1, accepted samples alternate between state slots 0 and 1, starting at slot 0, and the two slots are independent. With `stereo` = 0, only slot 0 is used.
- R8: A cycle with `clr_state` high zeroes all four state words and returns the interleave position to slot 0. `in_ready` is low during that cycle.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_sample` stays stable in the next cycle. `in_ready` is low in that condition.
- R10: State words wrap modulo 2^32 with no saturation. Only the result is saturated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stereo | input | 1 | 0: mono, 1: two interleaved channels |
| clr_state | input | 1 | Zero all state and the interleave position |
| coef_b0 | input | 32 | Feed-forward tap 0, Q28 |
| coef_b1 | input | 32 | Feed-forward tap 1, Q28 |
| coef_b2 | input | 32 | Feed-forward tap 2, Q28 |
| coef_a1 | input | 32 | Feedback tap 1, Q28, applied negated |
| coef_a2 | input | 32 | Feedback tap 2, Q28, applied negated |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_sample | input | 16 | Signed input sample |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_sample | output | 16 | Signed saturated result |

## Verification
The bench targets these corner cases:
- **Feedback rounding.** Feedback near marginal stability exposes a wrong rounding constant or a truncating shift, because the error builds up in the state until the results drift off the model.
- **Saturation.** Large gains drive the result into both limits. A design that wraps instead of clamping returns a value of the wrong sign.
- **Extreme coefficients.** A feedback tap of −2^31 and large feed-forward taps force the state to wrap, which a design that saturates the state would get wrong.
- **Interleaving.** Interleaved streams with an odd count before a clear catch a slot pointer that fails to reset or that leaks state between channels.
- **Back-pressure.** Random stalls catch a dropped or duplicated result.

// File: rtl/biquad_pkg.sv
package biquad_pkg;
  parameter int SAMP_W  = 16;
  parameter int COEF_W  = 32;
  parameter int STATE_W = 32;
  parameter int FF_SHIFT = 16;
  parameter int FB_FRAC  = 30;
  parameter int Y_QBITS  = 14;
  parameter int Y_LSHIFT = 2;
  parameter int NUM_CH   = 2;

  typedef logic signed [STATE_W-1:0] state_t;
  typedef logic signed [SAMP_W-1:0]  samp_t;
endpackage

// File: rtl/biquad_ff_mac.sv
module biquad_ff_mac #(
  parameter int CW = 32,
  parameter int XW = 16,
  parameter int AW = 32,
  parameter int SHIFT = 16
) (
  input  logic signed [AW-1:0] acc,
  input  logic signed [CW-1:0] coef,
  input  logic signed [XW-1:0] x,
  output logic signed [AW-1:0] sum
);
  localparam int PW = CW + XW;
  logic signed [PW-1:0] prod;

  always_comb begin
    prod = coef * x;
    sum  = acc + prod[SHIFT +: AW];
  end
endmodule

// File: rtl/biquad_fb_round.sv
module biquad_fb_round #(
  parameter int W = 32,
  parameter int FRAC = 30
) (
  input  logic signed [W-1:0] y,
  input  logic signed [W-1:0] a,
  output logic signed [W-1:0] term
);
  localparam int PW = 2 * W;
  logic signed [W-1:0]  neg_a;
  logic signed [PW-1:0] ye, ae, prod, rnd;

  always_comb begin
    neg_a = -a;
    ye    = {{W{y[W-1]}}, y};
    ae    = {{W{neg_a[W-1]}}, neg_a};
    prod  = ye * ae;
    rnd   = prod + (PW'(1) <<< (FRAC - 1));
    term  = rnd[FRAC +: W];
  end
endmodule

// File: rtl/biquad_out_sat.sv
module biquad_out_sat #(
  parameter int W = 32,
  parameter int QS = 14,
  parameter int OW = 16
) (
  input  logic signed [W-1:0]  y,
  output logic signed [OW-1:0] q
);
  localparam int SW = W - QS;
  localparam int HI = SW - OW + 1;
  logic signed [W-1:0]  biased;
  logic signed [SW-1:0] scaled;
  logic [HI-1:0]        top;

  always_comb begin
    biased = y + W'((1 << QS) - 1);
    scaled = biased[W-1:QS];
    top    = scaled[SW-1:OW-1];
    if (top == '0 || top == '1) q = scaled[OW-1:0];
    else if (scaled[SW-1])      q = {1'b1, {(OW-1){1'b0}}};
    else                        q = {1'b0, {(OW-1){1'b1}}};
  end
endmodule

// File: rtl/biquad_df2t.sv
module biquad_df2t
  import biquad_pkg::*;
#(
  parameter int SW = SAMP_W,
  parameter int CW = COEF_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stereo,
  input  logic                 clr_state,
  input  logic signed [CW-1:0] coef_b0,
  input  logic signed [CW-1:0] coef_b1,
  input  logic signed [CW-1:0] coef_b2,
  input  logic signed [CW-1:0] coef_a1,
  input  logic signed [CW-1:0] coef_a2,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [SW-1:0] in_sample,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [SW-1:0] out_sample
);
  localparam int STW = STATE_W;
  localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  state_t          s0_q [NUM_CH];
  state_t          s1_q [NUM_CH];
  logic [CHW-1:0]  slot_q, slot;
  state_t          cur_s0, cur_s1;
  state_t          mac0, y_q14, fb0, fb1, s1_plus, nxt_s0, nxt_s1;
  logic signed [SW-1:0] res;
  logic            accept;

  assign in_ready = (!out_valid || out_ready) && !clr_state;
  assign accept   = in_valid && in_ready;
  assign slot     = stereo ? slot_q : '0;

  always_comb begin
    cur_s0 = s0_q[slot];
    cur_s1 = s1_q[slot];
  end

  biquad_ff_mac #(.CW(CW), .XW(SW), .AW(STW), .SHIFT(FF_SHIFT)) u_mac0 (
    .acc(cur_s0), .coef(coef_b0), .x(in_sample), .sum(mac0));

  assign y_q14 = mac0 <<< Y_LSHIFT;

  biquad_fb_round #(.W(STW), .FRAC(FB_FRAC)) u_fb0 (
    .y(y_q14), .a(coef_a1), .term(fb0));
  biquad_fb_round #(.W(STW), .FRAC(FB_FRAC)) u_fb1 (
    .y(y_q14), .a(coef_a2), .term(fb1));

  assign s1_plus = cur_s1 + fb0;

  biquad_ff_mac #(.CW(CW), .XW(SW), .AW(STW), .SHIFT(FF_SHIFT)) u_mac1 (
    .acc(s1_plus), .coef(coef_b1), .x(in_sample), .sum(nxt_s0));
  biquad_ff_mac #(.CW(CW), .XW(SW), .AW(STW), .SHIFT(FF_SHIFT)) u_mac2 (
    .acc(fb1), .coef(coef_b2), .x(in_sample), .sum(nxt_s1));

  biquad_out_sat #(.W(STW), .QS(Y_QBITS), .OW(SW)) u_sat (
    .y(y_q14), .q(res));

  // per-channel state banks
  for (genvar g = 0; g < NUM_CH; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n || clr_state) begin
        s0_q[g] <= '0;
        s1_q[g] <= '0;
      end else if (accept && slot == CHW'(g)) begin
        s0_q[g] <= nxt_s0;
        s1_q[g] <= nxt_s1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_state) slot_q <= '0;
    else if (accept)         slot_q <= stereo ? CHW'(slot_q + 1'b1) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_sample <= res;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);                          // R9
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_sample));                // R9
  AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);                                           // R2
  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !accept |=> !out_valid);               // R2
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_state |=> s0_q[0] == '0 && s1_q[0] == '0 && s0_q[NUM_CH-1] == '0
                  && s1_q[NUM_CH-1] == '0 && slot_q == '0);          // R8
  AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && stereo |=> slot_q != $past(slot_q));                   // R7
endmodule

// File: tb/biquad_df2t_test.sv
module biquad_df2t_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stereo = 1'b0, clr_state = 1'b0;
  logic signed [31:0] b0 = 0, b1 = 0, b2 = 0, a1 = 0, a2 = 0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic signed [15:0] in_sample = 0;
  wire  in_ready, out_valid;
  wire  signed [15:0] out_sample;

  biquad_df2t uut (
    .clk(clk), .rst_n(rst_n), .stereo(stereo), .clr_state(clr_state),
    .coef_b0(b0), .coef_b1(b1), .coef_b2(b2), .coef_a1(a1), .coef_a2(a2),
    .in_valid(in_valid), .in_ready(in_ready), .in_sample(in_sample),
    .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  int st[4];
  bit nxt_slot = 0;
  int exp_q[$];
  string tag = "R1";
  bit bp_en = 0, mon_on = 0;
  bit was_accept = 0, was_hold = 0;
  logic signed [15:0] held_val;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int ff(input int c, input int x);
    longint p = longint'(c) * longint'(x);
    return int'(p >>> 16);
  endfunction

  function automatic int fb(input int y, input int a);
    int na = -a;
    longint p = longint'(y) * longint'(na) + 64'sd536870912;
    return int'(p >>> 30);
  endfunction

  function automatic int model_step(input int x);
    int base, y, t, r;
    base = (stereo && nxt_slot) ? 2 : 0;
    y = (st[base] + ff(b0, x)) << 2;
    t = st[base + 1] + fb(y, a1) + ff(b1, x);
    st[base + 1] = fb(y, a2) + ff(b2, x);
    st[base] = t;
    r = (y + 16383) >>> 14;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    nxt_slot = stereo ? !nxt_slot : 1'b0;
    return r;
  endfunction

  always @(negedge clk) out_ready <= bp_en ? (($urandom % 3) != 0) : 1'b1;

  // reference monitor, sampled 1 ns before each rising edge
  always @(negedge clk) begin
    #1;
    cycles++;
    if (mon_on) begin
      if (was_accept) chk(out_valid === 1'b1, "R2 valid after accept", int'(out_valid), 1);
      if (was_hold) begin
        chk(out_valid === 1'b1 && out_sample === held_val, "R9 hold", int'(out_sample), int'(held_val));
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R2 extra output", int'(out_sample), 0);
        else chk(out_sample === 16'(exp_q[0]), tag, int'(out_sample), exp_q[0]);
        if (exp_q.size() != 0) void'(exp_q.pop_front());
      end
      was_hold = out_valid && !out_ready;
      held_val = out_sample;
      was_accept = in_valid && in_ready;
      if (clr_state) begin
        chk(in_ready === 1'b0, "R8 in_ready low in clear", int'(in_ready), 0);
        st = '{0, 0, 0, 0};
        nxt_slot = 0;
      end else if (in_valid && in_ready) begin
        exp_q.push_back(model_step(int'(in_sample)));
      end
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic send(input int x);
    in_valid = 1'b1;
    in_sample = 16'(x);
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    in_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_coefs(input int c0, input int c1, input int c2,
                           input int f1, input int f2);
    b0 = c0; b1 = c1; b2 = c2; a1 = f1; a2 = f2;
  endtask

  task automatic clear_pulse();
    clr_state = 1'b1;
    @(negedge clk);
    clr_state = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    st = '{0, 0, 0, 0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid === 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready === 1'b1, "R1 in_ready", int'(in_ready), 1);
    @(negedge clk);
    mon_on = 1;

    // R3: unity feed-forward passes samples through
    tag = "R3 unity path";
    set_coefs(32'sh1000_0000, 0, 0, 0, 0);
    send(0); send(1); send(-1); send(12345); send(-32768); send(32767);
    drain();

    // R4 R5: low-pass with strong feedback and rounding buildup
    tag = "R4 R5 feedback";
    set_coefs(26843546, 53687091, 26843546, -429496730, 187904819);
    send(20000);
    for (int i = 0; i < 40; i++) send(0);
    for (int i = 0; i < 60; i++) send(int'($urandom % 65536) - 32768);
    drain();

    // R6: saturation at both limits
    tag = "R6 saturation";
    clear_pulse();
    set_coefs(32'sh4000_0000, 0, 0, 0, 0);
    send(30000); send(-30000); send(8191); send(-8193); send(8192); send(-8192);
    drain();

    // R10: extreme coefficients force state wrap
    tag = "R10 wrap";
    set_coefs(32'sh7fff_ffff, 32'sh7fff_ffff, 32'sh8000_0000, 32'sh8000_0000, 32'sh7fff_ffff);
    for (int i = 0; i < 24; i++) send((i % 2) ? 32767 : -32768);
    drain();

    // R7 R9: interleaved channels under back-pressure, odd count
    tag = "R7 R9 stereo";
    clear_pulse();
    set_coefs(26843546, 53687091, 26843546, -429496730, 187904819);
    stereo = 1'b1;
    @(negedge clk);
    bp_en = 1;
    for (int i = 0; i < 101; i++) send((i % 2) ? 3000 : int'($urandom % 40000) - 20000);
    drain();
    bp_en = 0;

    // R8: clear mid-stream restores slot 0 and zero state
    tag = "R8 after clear";
    clear_pulse();
    for (int i = 0; i < 10; i++) send(1000 * (i + 1));
    drain();

    // R7: back to mono after stereo, slot 0 only
    tag = "R7 mono";
    stereo = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 20; i++) send(int'($urandom % 65536) - 32768);
    drain();

    chk(exp_q.size() == 0, "R2 all outputs delivered", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule